// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a four-bit synchronous up-counter that can be cleared and preset. Every bit of the count register updates on the rising clock edge. An active-low load copies a four-bit data word into the count. Two active-high enables must both be high for the count to advance. A terminal-count carry output lets several stages be chained into a wider counter.

Clear is active low. A compile-time parameter selects whether clear acts at once, without waiting for the clock, or only on a rising edge. Clear takes priority over load, and load takes priority over counting. The carry is high only while the count is all ones and the second enable (`en_t`) is high. The first enable (`en_p`) can stop counting but has no effect on the carry.

Wider counters are built by feeding each stage's carry into the `en_t` input of the next stage. `en_p` stays free as a global count inhibit.

Top module: `presettable_counter`

## Requirements
- R1: The count is `WIDTH` bits wide (default 4). All bits change together, only on a rising edge of `clk`, except for an asynchronous clear. Bit 0 of `din` goes to bit 0 of `q`, the least significant bit.
- R2: With `CLR_MODE` = `CLR_ASYNC`, driving `clr_n` low forces `q` to zero within the same cycle, without waiting for a clock edge.
- R3: When `load_n` is low and `clr_n` is high at a rising edge, `q` takes the value of `din`. No counting happens on that edge, whatever the enables are.
- R4: With `CLR_MODE` = `CLR_SYNC`, `q` keeps its value while `clr_n` is low between edges. It becomes zero only at the next rising edge.
- R5: When `clr_n`, `load_n`, `en_p` and `en_t` are all high at a rising edge, `q` increments by one. It wraps from 15 to 0 with no extra state.
- R6: When `clr_n` and `load_n` are high and either enable is low at a rising edge, `q` holds its value.
- R7: `carry` is combinational and equals `en_t` AND (`q` == 15). `en_p` has no effect on it, so a change on `en_t` alone changes `carry` in the same cycle.
- R8: A clear takes priority over a load. With both `clr_n` and `load_n` low at a rising edge, `q` is zero after that edge.
- R9: Two stages can be chained. The first stage has `en_t` held high, the second stage takes the first stage's `carry` on its `en_t`, and `en_p` is high on both. Together they count 0 to 255 in order and then wrap to 0, and both carries are high at 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous according to `CLR_MODE` |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Count enable; does not affect the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| din | input | WIDTH | Preset data; bit 0 is the least significant bit |
| q | output | WIDTH | Current count |
| carry | output | 1 | Terminal-count carry for cascading |

## Verification
All of the state is in the count register, which drives `q` directly. A wrong next-state choice therefore shows up at the ports on the very next rising edge, either as a bad value on `q` or as a `carry` at the wrong moment. A clear routed to the wrong timing shows up within one cycle: an asynchronous clear that waits for the edge, or a synchronous clear that acts early, both appear at `q` between edges. The chained run checks that the carry is decoded correctly: a carry raised on the wrong count would break the upper stage's sequence within 16 edges.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  // How the clear input acts on the count register
  typedef enum logic {
    CLR_ASYNC = 1'b0,
    CLR_SYNC  = 1'b1
  } clr_mode_e;

  // Next-state operation chosen for one clock edge, in priority order
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;

endpackage

// File: rtl/ctr_decode.sv
module ctr_decode (
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  output ctr_pkg::ctr_op_e op
);
  import ctr_pkg::*;

  // Priority: clear, then load, then count, else hold
  function automatic ctr_op_e pick_op(input logic c_n, input logic l_n,
                                      input logic ep, input logic et);
    if (!c_n)          return OP_CLEAR;
    else if (!l_n)     return OP_LOAD;
    else if (ep && et) return OP_INC;
    else               return OP_HOLD;
  endfunction

  always_comb op = pick_op(clr_n, load_n, en_p, en_t);

endmodule

// File: rtl/ctr_state.sv
module ctr_state #(
  parameter int                 WIDTH    = 4,
  parameter ctr_pkg::clr_mode_e CLR_MODE = ctr_pkg::CLR_ASYNC
) (
  input  logic               clk,
  input  logic               clr_n,
  input  ctr_pkg::ctr_op_e   op,
  input  logic [WIDTH-1:0]   din,
  output logic [WIDTH-1:0]   q
);
  import ctr_pkg::*;

  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  function automatic logic [WIDTH-1:0] next_count(input logic [WIDTH-1:0] cur,
                                                  input ctr_op_e sel,
                                                  input logic [WIDTH-1:0] pre);
    case (sel)
      OP_CLEAR: return '0;
      OP_LOAD:  return pre;
      OP_INC:   return cur + STEP;
      default:  return cur;
    endcase
  endfunction

  logic [WIDTH-1:0] cnt_r;
  logic [WIDTH-1:0] cnt_nxt;

  always_comb cnt_nxt = next_count(cnt_r, op, din);

  generate
    if (CLR_MODE == CLR_ASYNC) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cnt_r <= '0;
        else        cnt_r <= cnt_nxt;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        cnt_r <= cnt_nxt;
      end
    end
  endgenerate

  assign q = cnt_r;

endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             carry
);
  localparam logic [WIDTH-1:0] Q_TOP = '1;

  function automatic logic term_count(input logic [WIDTH-1:0] v, input logic gate);
    return gate && (v == Q_TOP);
  endfunction

  always_comb carry = term_count(q, en_t);

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter #(
  parameter int                 WIDTH    = 4,
  parameter ctr_pkg::clr_mode_e CLR_MODE = ctr_pkg::CLR_ASYNC
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry
);
  ctr_pkg::ctr_op_e edge_op;
  logic [WIDTH-1:0] cnt_q;

  ctr_decode u_decode (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (edge_op)
  );

  ctr_state #(.WIDTH(WIDTH), .CLR_MODE(CLR_MODE)) u_state (
    .clk   (clk),
    .clr_n (clr_n),
    .op    (edge_op),
    .din   (din),
    .q     (cnt_q)
  );

  ctr_carry #(.WIDTH(WIDTH)) u_carry (
    .q     (cnt_q),
    .en_t  (en_t),
    .carry (carry)
  );

  assign q = cnt_q;

endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
  parameter int                 WIDTH    = 4,
  parameter ctr_pkg::clr_mode_e CLR_MODE = ctr_pkg::CLR_ASYNC
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> q == ($past(q) + ONE)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q)); // R6

  AST_CARRY_NEEDS_TOP: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> (en_t && (&q))); // R7

  AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (!clr_n)
    (en_t && (&q)) |-> carry); // R7

  AST_CLEAR_BEATS_ALL: assert property (@(posedge clk)
    $past(!clr_n) |-> q == '0); // R8

  generate
    if (CLR_MODE == ctr_pkg::CLR_ASYNC) begin : g_async_chk
      AST_ASYNC_CLEAR_NOW: assert property (@(negedge clk)
        !clr_n |-> q == '0); // R2
    end
  endgenerate

endmodule

bind presettable_counter ctr_checker #(.WIDTH(WIDTH), .CLR_MODE(CLR_MODE)) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .load_n (load_n),
  .en_p   (en_p),
  .en_t   (en_t),
  .din    (din),
  .q      (q),
  .carry  (carry)
);

// File: tb/test_presettable_counter.sv
module test_presettable_counter;
  import ctr_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic       clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = 4'h0;
  logic [3:0] q_a, q_s;
  logic       c_a, c_s;

  presettable_counter #(.WIDTH(4), .CLR_MODE(CLR_ASYNC)) i_presettable_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q_a), .carry(c_a));

  presettable_counter #(.WIDTH(4), .CLR_MODE(CLR_SYNC)) i_sync (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q_s), .carry(c_s));

  // two chained stages
  logic       ch_clr_n = 1'b0, ch_en = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_c, hi_c;

  presettable_counter #(.WIDTH(4)) i_lo (
    .clk(clk), .clr_n(ch_clr_n), .load_n(1'b1), .en_p(ch_en), .en_t(1'b1),
    .din(4'h0), .q(lo_q), .carry(lo_c));

  presettable_counter #(.WIDTH(4)) i_hi (
    .clk(clk), .clr_n(ch_clr_n), .load_n(1'b1), .en_p(ch_en), .en_t(lo_c),
    .din(4'h0), .q(hi_q), .carry(hi_c));

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic [3:0] m_q = 4'h0;

  typedef struct {
    int         due;
    logic [3:0] q;
    logic       c;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected post-edge state
  task automatic step(input logic c, input logic l, input logic p, input logic t,
                      input logic [3:0] d);
    exp_t e;
    logic [3:0] old_q;
    @(posedge clk);
    #3;
    clr_n = c; load_n = l; en_p = p; en_t = t; din = d;
    old_q = m_q;
    if (!c) begin
      m_q = 4'h0;     e.tag = l ? "R8 clear" : "R8 clear-over-load";
    end else if (!l) begin
      m_q = d;        e.tag = "R3 load";
    end else if (p && t) begin
      m_q = m_q + 4'h1; e.tag = "R5 count";
    end else begin
      e.tag = "R6 hold";
    end
    e.due = cyc + 1;
    e.q   = m_q;
    e.c   = t && (m_q == 4'hF);
    sbq.push_back(e);
    if (!c) begin
      #2;
      chk(q_a == 4'h0, "R2 async clear between edges", q_a, 0);
      chk(q_s == old_q, "R4 sync clear waits for edge", q_s, old_q);
    end
  endtask

  // monitor: compare outputs shortly after each edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      exp_t e;
      e = sbq.pop_front();
      chk(q_a == e.q, {e.tag, " async inst q"}, q_a, e.q);
      chk(q_s == e.q, {e.tag, " sync inst q"},  q_s, e.q);
      chk(c_a == e.c, "R7 carry async inst", c_a, e.c);
      chk(c_s == e.c, "R7 carry sync inst",  c_s, e.c);
    end
  end

  bit done = 1'b0;

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // reset state and clear priority (R8)
    step(0, 1, 0, 0, 4'h0);
    step(0, 0, 1, 1, 4'h9);
    // preset to 12, count 13,14,15,0,1,2 then inhibit
    step(1, 0, 1, 1, 4'hC);               // R3
    for (int i = 0; i < 6; i++) step(1, 1, 1, 1, 4'h0); // R5 wrap
    step(1, 1, 0, 0, 4'h0);               // R6
    step(1, 1, 0, 0, 4'h0);
    step(1, 1, 0, 1, 4'h0);               // R6 only en_t
    step(1, 1, 1, 0, 4'h0);               // R6 only en_p
    // carry with en_p low (R7)
    step(1, 0, 0, 1, 4'hF);
    step(1, 1, 0, 1, 4'h0);
    step(1, 1, 1, 0, 4'h0);               // R7 en_t gates carry
    step(1, 1, 1, 1, 4'h0);               // R5 15 -> 0
    // load overrides counting, bit order (R1, R3)
    step(1, 0, 1, 1, 4'b0001);
    step(1, 0, 1, 1, 4'b1000);
    step(1, 1, 1, 1, 4'h0);
    step(1, 1, 1, 1, 4'h0);
    // clear mid-count (R2, R4)
    step(0, 1, 1, 1, 4'h0);
    step(1, 0, 1, 1, 4'hE);
    step(1, 1, 1, 1, 4'h0);
    step(1, 1, 1, 1, 4'h0);
    step(1, 1, 0, 0, 4'h0);
    repeat (3) @(posedge clk);
    #3;
    chk(sbq.size() == 0, "R1 scoreboard drained", sbq.size(), 0);

    // R9: chained stages
    ch_clr_n = 1'b0; ch_en = 1'b0;
    @(posedge clk); #3;
    ch_clr_n = 1'b1; ch_en = 1'b1;
    for (int k = 1; k <= 257; k++) begin
      @(posedge clk); #1;
      chk({hi_q, lo_q} == 8'(k), "R9 chained count", {hi_q, lo_q}, k & 255);
      if ((k & 255) == 255)
        chk(lo_c && hi_c, "R9 both carries at 255", {lo_c, hi_c}, 3);
      else
        chk(!hi_c, "R9 upper carry only at 255", hi_c, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule